// File: doc/BRIEF.md
# Queued Threshold Alert Comparator

This block watches a stream of signed conversion results and raises an alert when the results leave a programmed band. Each result arrives with a one-cycle valid strobe. It is compared against a high and a low threshold, and both are held outside the block. A fault queue counts consecutive violating results, and the alert is raised only once that count reaches the selected depth. The queue can also be set to an off setting, which disables the whole comparator and releases the output pin.

Two comparison styles are provided. In hysteresis mode only results above the high threshold count as violations, and the alert drops once a result falls below the low threshold. In window mode a result outside either threshold counts, and the alert drops on the first result inside the band. A latching option holds a raised alert until the host reads the conversion data or answers an alert-response cycle. The pin polarity can be chosen, and an output-enable lets a pad tri-state the pin. Register access and bus decoding are handled elsewhere.

Top module: `qac_top`

## Requirements
- R1: Results and both thresholds are compared as DATA_W-bit two's-complement numbers; a result is "over" when strictly greater than thr_hi and "under" when strictly less than thr_lo.
- R2: With queue_sel 2'b00, 2'b01 or 2'b10 the alert is raised by the result that completes 1, 2 or 4 consecutive violating results respectively; only cycles with res_valid high are results.
- R3: Any valid result that is not a violation returns the consecutive-violation count to zero, so violations separated by such a result do not add up.
- R4: With queue_sel 2'b11 the comparator is off: alert_oe is low, alert_out sits at its inactive level, results are ignored, and the count and alert are cleared. The block leaves reset in this off state with no alert.
- R5: When alert_oe is high, pol_high 1 makes alert_out 1 while the alert is raised and 0 otherwise; pol_high 0 gives the opposite levels.
- R6: With win_mode 1 a violation is a result that is over or under; in non-latching mode the alert drops on the first valid result that is neither.
- R7: With win_mode 0 a violation is a result that is over; in non-latching mode the alert drops only on a valid result that is under, and results between the thresholds leave it raised.
- R8: With latch_en 1 a raised alert stays raised until a cycle with data_read or alert_ack high, and the alert then drops; a result that completes the queue in that same cycle keeps the alert raised.
- R9: With latch_en 0, data_read and alert_ack have no effect on the alert.
- R10: A change of queue_sel clears the count and the alert, and a result presented in the cycle of the change is discarded.
- R11: The alert state changes at the clock edge that samples the deciding result or strobe, and alert_out shows the new state in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | New conversion result this cycle |
| res_data | input | DATA_W | Signed conversion result |
| thr_hi | input | DATA_W | Signed high threshold |
| thr_lo | input | DATA_W | Signed low threshold |
| win_mode | input | 1 | 1 selects window mode, 0 selects hysteresis mode |
| pol_high | input | 1 | 1 makes the raised alert drive a 1 |
| latch_en | input | 1 | 1 makes the alert latching |
| queue_sel | input | 2 | Fault-queue depth: 00 one, 01 two, 10 four, 11 off |
| data_read | input | 1 | Host read of the conversion data |
| alert_ack | input | 1 | Alert-response cycle completed |
| alert_out | output | 1 | Alert pin level |
| alert_oe | output | 1 | Pin output enable, low means high-impedance |

## Verification
Results just above, just below and exactly on each threshold, together with the most negative code, separate signed from unsigned compares and strict from inclusive compares. Bursts of violations of different lengths, some broken by a single in-band result, show whether the queue depth for each setting is right and whether the count really restarts. Between-threshold results after an alert separate hysteresis from window clearing. Strobes sent with and without latching, queue changes that coincide with a result, and a long random phase with changing settings each reveal a different wrong priority between setting, clearing and flushing.

// File: rtl/qac_pkg.sv
package qac_pkg;

    // Deepest fault queue supported and the count width it needs.
    parameter int unsigned QAC_QMAX  = 4;
    parameter int unsigned QAC_CNT_W = $clog2(QAC_QMAX + 1);

    typedef enum logic [1:0] {
        QSEL_ONE  = 2'b00,
        QSEL_TWO  = 2'b01,
        QSEL_FOUR = 2'b10,
        QSEL_OFF  = 2'b11
    } qsel_e;

    // Number of consecutive violations that raise the alert.
    function automatic logic [QAC_CNT_W-1:0] qac_need(input logic [1:0] sel);
        logic [QAC_CNT_W-1:0] n;
        case (qsel_e'(sel))
            QSEL_ONE:  n = QAC_CNT_W'(1);
            QSEL_TWO:  n = QAC_CNT_W'(2);
            QSEL_FOUR: n = QAC_CNT_W'(4);
            default:   n = QAC_CNT_W'(QAC_QMAX);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/qac_classify.sv
module qac_classify #(
    parameter int unsigned DATA_W = 12
) (
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              win_mode,
    output logic              viol,
    output logic              release_ok
);
    logic over;
    logic under;

    always_comb begin
        over  = $signed(res_data) > $signed(thr_hi);
        under = $signed(res_data) < $signed(thr_lo);
        if (win_mode) begin
            viol       = over | under;
            release_ok = ~(over | under);
        end else begin
            viol       = over;
            release_ok = under;
        end
    end
endmodule

// File: rtl/qac_fault_queue.sv
module qac_fault_queue #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             valid,
    input  logic             viol,
    input  logic [CNT_W-1:0] need,
    output logic             hit,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } fq_state_t;

    fq_state_t    st_d, st_q;
    logic [CNT_W:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        hit     = 1'b0;
        cnt_inc = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        if (clear) begin
            st_d.cnt = '0;
        end else if (valid) begin
            if (viol) begin
                if (cnt_inc >= {1'b0, need}) begin
                    hit      = 1'b1;
                    st_d.cnt = need;
                end else begin
                    st_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/qac_alert_state.sv
module qac_alert_state (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic hit,
    input  logic valid,
    input  logic release_ok,
    input  logic latch_en,
    input  logic host_clr,
    output logic active
);
    typedef struct packed {
        logic active;
    } al_state_t;

    al_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.active = 1'b0;
        end else if (hit) begin
            st_d.active = 1'b1;
        end else if (latch_en) begin
            if (host_clr) st_d.active = 1'b0;
        end else if (valid && release_ok) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
endmodule

// File: rtl/qac_top.sv
module qac_top
    import qac_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic              win_mode,
    input  logic              pol_high,
    input  logic              latch_en,
    input  logic [1:0]        queue_sel,
    input  logic              data_read,
    input  logic              alert_ack,
    output logic              alert_out,
    output logic              alert_oe
);
    localparam int unsigned CNT_W = QAC_CNT_W;

    typedef struct packed {
        logic [1:0] qsel;
    } top_state_t;

    top_state_t       ts_d, ts_q;
    logic             flush;
    logic             off;
    logic             clear_all;
    logic             valid_eff;
    logic             viol;
    logic             release_ok;
    logic             hit;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;

    always_comb begin
        ts_d      = ts_q;
        ts_d.qsel = queue_sel;
        off       = (qsel_e'(queue_sel) == QSEL_OFF);
        flush     = (queue_sel != ts_q.qsel);
        clear_all = flush | off;
        valid_eff = res_valid & ~clear_all;
        need      = qac_need(queue_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '{qsel: QSEL_OFF};
        else        ts_q <= ts_d;
    end

    qac_classify #(.DATA_W(DATA_W)) u_cls (
        .res_data   (res_data),
        .thr_hi     (thr_hi),
        .thr_lo     (thr_lo),
        .win_mode   (win_mode),
        .viol       (viol),
        .release_ok (release_ok)
    );

    qac_fault_queue #(.CNT_W(CNT_W)) u_fq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_all),
        .valid (valid_eff),
        .viol  (viol),
        .need  (need),
        .hit   (hit),
        .cnt   (cnt)
    );

    qac_alert_state u_al (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_all),
        .hit        (hit),
        .valid      (valid_eff),
        .release_ok (release_ok),
        .latch_en   (latch_en),
        .host_clr   (data_read | alert_ack),
        .active     (active)
    );

    always_comb begin
        alert_oe  = ~off;
        alert_out = (active & ~off) ^ ~pol_high;
    end
endmodule

// File: rtl/qac_checker.sv
module qac_checker #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_valid,
    input logic             data_read,
    input logic             alert_ack,
    input logic             latch_en,
    input logic [1:0]       queue_sel,
    input logic             flush,
    input logic             active,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] need
);
    // R4: off setting leaves no alert behind
    assert_off_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_sel == 2'b11) |=> !active);

    // R8: latched alert holds without a host strobe
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && active && !data_read && !alert_ack && !flush && queue_sel != 2'b11)
        |=> active);

    // R11: alert only rises after a sampled result
    assert_rise_on_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(res_valid));

    // R9: strobes alone do nothing in non-latching mode
    assert_strobe_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && !res_valid && !flush && queue_sel != 2'b11) |=> $stable(active));

    // R10: queue change flushes count and alert
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!active && cnt == '0));

    // R3: count never passes the selected depth
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (cnt <= need));
endmodule

bind qac_top qac_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .data_read (data_read),
    .alert_ack (alert_ack),
    .latch_en  (latch_en),
    .queue_sel (queue_sel),
    .flush     (flush),
    .active    (active),
    .cnt       (cnt),
    .need      (need)
);

// File: tb/tb_qac_top.sv
module tb_qac_top;
    localparam int DATA_W  = 12;
    localparam time CLK_PER = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              res_valid = 1'b0;
    logic [DATA_W-1:0] res_data = '0;
    logic [DATA_W-1:0] thr_hi = 12'd100;
    logic [DATA_W-1:0] thr_lo = 12'hF9C;
    logic              win_mode = 1'b0;
    logic              pol_high = 1'b0;
    logic              latch_en = 1'b0;
    logic [1:0]        queue_sel = 2'b11;
    logic              data_read = 1'b0;
    logic              alert_ack = 1'b0;
    logic              alert_out;
    logic              alert_oe;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R4";

    always #(CLK_PER/2) clk = ~clk;

    qac_top #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .win_mode(win_mode), .pol_high(pol_high),
        .latch_en(latch_en), .queue_sel(queue_sel), .data_read(data_read),
        .alert_ack(alert_ack), .alert_out(alert_out), .alert_oe(alert_oe)
    );

    // Behavioural reference model
    int m_cnt, m_need, m_d;
    bit m_act, m_hit, m_rel, m_ov, m_un, m_vi, m_fl;
    logic [1:0] m_prevq;

    function automatic int sx(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? int'(v) - (1 << DATA_W) : int'(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_prevq = 2'b11;
        end else begin
            m_fl = (queue_sel != m_prevq);
            m_prevq = queue_sel;
            if (m_fl || queue_sel == 2'b11) begin
                m_cnt = 0; m_act = 0;
            end else begin
                m_hit = 0; m_rel = 0;
                if (res_valid) begin
                    m_d  = sx(res_data);
                    m_ov = m_d > sx(thr_hi);
                    m_un = m_d < sx(thr_lo);
                    m_vi = win_mode ? (m_ov || m_un) : m_ov;
                    m_need = 1 << queue_sel;
                    if (m_vi) begin
                        m_cnt = m_cnt + 1;
                        if (m_cnt >= m_need) begin m_cnt = m_need; m_hit = 1; end
                    end else m_cnt = 0;
                    m_rel = !latch_en && (win_mode ? !m_vi : m_un);
                end
                if (m_hit) m_act = 1;
                else if (m_rel || (latch_en && (data_read || alert_ack))) m_act = 0;
            end
        end
    end

    task automatic compare();
        bit e_oe, e_on, e_out;
        e_oe  = (queue_sel != 2'b11);
        e_on  = m_act && e_oe;
        e_out = pol_high ? e_on : !e_on;
        checks++;
        if (alert_oe !== e_oe || alert_out !== e_out) begin
            fails++;
            $display("FAIL %s: oe=%b out=%b expected oe=%b out=%b at %0t",
                     cur_req, alert_oe, alert_out, e_oe, e_out, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        tick(); res_valid = 0; data_read = 0; alert_ack = 0;
    endtask

    task automatic res(input int v);
        tick(); res_valid = 1; res_data = DATA_W'(v); data_read = 0; alert_ack = 0;
    endtask

    task automatic cfg(input logic [1:0] q, input bit w, input bit p, input bit l);
        tick(); res_valid = 0; data_read = 0; alert_ack = 0;
        queue_sel = q; win_mode = w; pol_high = p; latch_en = l;
        idle();
    endtask

    task automatic expect_on(input bit e, input string req);
        bit act;
        act = alert_oe && (alert_out == pol_high);
        checks++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: alert raised=%b expected %b at %0t", req, act, e, $time);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R4: reset state is off, pin released, inactive level
        cur_req = "R4";
        idle();
        checks++;
        if (alert_oe !== 1'b0 || alert_out !== 1'b1) begin
            fails++;
            $display("FAIL R4: oe=%b out=%b expected oe=0 out=1", alert_oe, alert_out);
        end

        // R7 hysteresis, depth one
        cur_req = "R7";
        cfg(2'b00, 0, 0, 0);
        res(101); idle(); expect_on(1, "R2");
        res(100); idle(); expect_on(1, "R7");
        res(0);   idle(); expect_on(1, "R7");
        res(-100); idle(); expect_on(1, "R7");
        res(-101); idle(); expect_on(0, "R7");

        // R1 signed compare: most negative code is not over the high threshold
        cur_req = "R1";
        res(12'h800); idle(); expect_on(0, "R1");
        res(12'hFFF); idle(); expect_on(0, "R1");
        cfg(2'b00, 1, 0, 0);
        res(12'h800); idle(); expect_on(1, "R1");

        // R6 window clears on in-band result
        cur_req = "R6";
        res(0); idle(); expect_on(0, "R6");
        res(101); idle(); expect_on(1, "R6");
        res(100); idle(); expect_on(0, "R6");

        // R2 depth two
        cur_req = "R2";
        cfg(2'b01, 0, 0, 0);
        res(200); idle(); expect_on(0, "R2");
        res(200); idle(); expect_on(1, "R2");

        // R3 count restarts, depth four
        cur_req = "R3";
        cfg(2'b10, 0, 0, 0);
        res(200); res(200); res(200); res(0);
        res(200); res(200); res(200); idle(); expect_on(0, "R3");
        res(200); idle(); expect_on(1, "R2");

        // R5 polarity
        cur_req = "R5";
        cfg(2'b00, 0, 1, 0);
        idle(); expect_on(0, "R5");
        checks++;
        if (alert_out !== 1'b0) begin fails++; $display("FAIL R5: out=%b expected 0", alert_out); end
        res(300); idle();
        checks++;
        if (alert_out !== 1'b1) begin fails++; $display("FAIL R5: out=%b expected 1", alert_out); end

        // R9 strobes ignored without latching
        cur_req = "R9";
        tick(); res_valid = 0; data_read = 1; idle(); expect_on(1, "R9");
        tick(); alert_ack = 1; idle(); expect_on(1, "R9");

        // R8 latching
        cur_req = "R8";
        cfg(2'b00, 0, 0, 1);
        res(300); idle(); expect_on(1, "R8");
        res(-300); idle(); expect_on(1, "R8");
        tick(); data_read = 1; idle(); expect_on(0, "R8");
        res(300); idle(); expect_on(1, "R8");
        tick(); alert_ack = 1; idle(); expect_on(0, "R8");
        tick(); res_valid = 1; res_data = 12'd300; data_read = 1; idle(); expect_on(1, "R8");

        // R10 queue change clears and discards
        cur_req = "R10";
        tick(); queue_sel = 2'b01; idle(); expect_on(0, "R10");
        tick(); queue_sel = 2'b00; res_valid = 1; res_data = 12'd300; idle(); expect_on(0, "R10");
        res(300); idle(); expect_on(1, "R11");

        // R4 off ignores results
        cur_req = "R4";
        tick(); queue_sel = 2'b11; res_valid = 1; res_data = 12'd300; idle();
        res(300); idle(); expect_on(0, "R4");
        checks++;
        if (alert_oe !== 1'b0) begin fails++; $display("FAIL R4: oe=%b expected 0", alert_oe); end

        // R11 random phase, model compared every cycle
        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            tick();
            res_valid = ($urandom_range(0, 1) == 1);
            case ($urandom_range(0, 3))
                0: res_data = DATA_W'($urandom);
                1: res_data = thr_hi + DATA_W'($urandom_range(0, 2)) - DATA_W'(1);
                2: res_data = thr_lo + DATA_W'($urandom_range(0, 2)) - DATA_W'(1);
                default: res_data = DATA_W'(0);
            endcase
            data_read = ($urandom_range(0, 19) == 0);
            alert_ack = ($urandom_range(0, 29) == 0);
            if ($urandom_range(0, 59) == 0) queue_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 79) == 0) begin
                win_mode = 1'($urandom); pol_high = 1'($urandom); latch_en = 1'($urandom);
            end
            if ($urandom_range(0, 299) == 0) begin
                thr_hi = DATA_W'($urandom_range(0, 400));
                thr_lo = DATA_W'(-$urandom_range(0, 400));
            end
        end
        idle(); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule